// File: doc/BRIEF.md
# On-Card RAM Size Discovery Tester

This block works out how much of an attached RAM behaves correctly. It cannot address the RAM directly. Every access goes through an indirect port with three targets: a write pointer, a read pointer, and a data location whose address advances by itself after each transfer. A data transfer is either one 16-bit word or one byte.

After a start pulse the tester tries candidate sizes. It begins at the largest and steps down by a fixed amount. For each candidate it runs a word pass and then a byte pass. Each pass clears memory, fills it with an arithmetic sequence, rewinds and reads it all back. The first candidate that survives both passes is reported. If every candidate fails, zero is reported. Either way the result comes with a one-cycle done pulse.

Requests leave on a valid/ready channel. A request stays on the pins, unchanged, until the port accepts it. Read data comes back on a separate response strobe that has no back-pressure. Only one read is ever outstanding: after a read request is accepted, no new request is raised until the response strobe arrives.

Top module: `ramsz_probe`

## Requirements
- R1: After reset, req_valid and done are 0 and size_bytes is 0.
- R2: Candidates are MAX_BYTES, MAX_BYTES-STEP_BYTES, and so on down to STEP_BYTES. done reports the first candidate that passes both passes, or 0 if none passes.
- R3: Each pass for candidate S issues these requests in order:
  - a write-pointer write;
  - HEAD_BYTES/2 word writes of 0 to data;
  - a write-pointer write;
  - S/2 word writes of 0;
  - a write-pointer write;
  - the fill writes;
  - a read-pointer write;
  - the reads.

  Every pointer write carries 0. Select codes are 0 for the write pointer, 1 for the read pointer and 2 for data. req_write is 1 for writes and 0 for reads. Clears and pointer writes have req_byte=0.
- R4: The word pass writes S/2 words with req_byte=0. Word k carries (1+3k) mod 65536.
- R5: The byte pass writes S bytes with req_byte=1. Byte k carries (1+3k) mod 256 in req_wdata[7:0], with req_wdata[15:8]=0. Reads in this pass also have req_byte=1, and only rsp_data[7:0] is compared.
- R6: Read k of a pass is compared with the same value that was written at position k. On the first mismatch no further read is issued for that candidate. The next request is the write-pointer write that starts the word pass of the next smaller candidate. If there is no smaller candidate, done is raised with 0.
- R7: The byte pass of a candidate starts only after all its word reads have matched. A mismatch in the byte pass abandons the candidate in the same way as in R6.
- R8: While req_valid=1 and req_ready=0, all request fields are held. After a read request is accepted, req_valid stays 0 until rsp_valid is seen. Read requests carry req_wdata=0.
- R9: done is high for exactly one cycle. size_bytes keeps the result until the next run ends.
- R10: A start pulse while a run is in progress has no effect on the request stream or on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the tester is idle |
| req_valid | output | 1 | A request is on the pins |
| req_ready | input | 1 | The port accepts the request this cycle |
| req_sel | output | 2 | Request target: 0 write pointer, 1 read pointer, 2 data |
| req_write | output | 1 | 1 for a write, 0 for a read |
| req_byte | output | 1 | 1 for a byte transfer, 0 for a word transfer |
| req_wdata | output | 16 | Write value |
| rsp_valid | input | 1 | Read data is present (single-cycle strobe) |
| rsp_data | input | 16 | Read data; for byte reads only the low byte counts |
| done | output | 1 | One-cycle pulse at the end of a run |
| size_bytes | output | SIZE_W | Size that passed, in bytes (18 bits by default) |

## Verification
A wrong sequencer state shows up at the port on the very next accepted request, as an unexpected select code, a wrong direction or width, or an extra or missing transfer. The bench compares the request stream entry by entry against a behavioural replay of the algorithm running on its own copy of the RAM. A faulty pattern or compare path shows up as a wrong write value at the fill position where it starts. Otherwise it shows up later, as a reported size that differs from the one the replay reaches. The RAM models used are aliased smaller RAMs, a RAM that drops odd byte writes, and a RAM with a stuck bit.

// File: rtl/ramsz_pkg.sv
package ramsz_pkg;
  typedef enum logic [1:0] {
    SEL_WPTR = 2'd0,
    SEL_RPTR = 2'd1,
    SEL_DATA = 2'd2
  } port_sel_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PTR_H,
    ST_CLR_H,
    ST_PTR_C,
    ST_CLR_C,
    ST_PTR_F,
    ST_FILL,
    ST_PTR_R,
    ST_RD_REQ,
    ST_RD_WAIT
  } st_t;
endpackage

// File: rtl/ramsz_patgen.sv
module ramsz_patgen #(
  parameter int DW   = 16,
  parameter int SEED = 1,
  parameter int INC  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  output logic [DW-1:0] pat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pat <= DW'(SEED);
    else if (load) pat <= DW'(SEED);
    else if (adv)  pat <= pat + DW'(INC);
  end

  // R4: each advance moves the sequence by the fixed step
  a_r4_pat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (pat == $past(pat) + DW'(INC)));
endmodule

// File: rtl/ramsz_loc_cnt.sv
module ramsz_loc_cnt #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == limit - 1'b1);

  // R3: no location beyond the current region is ever counted
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (cnt < limit));
endmodule

// File: rtl/ramsz_seq.sv
module ramsz_seq
  import ramsz_pkg::*;
#(
  parameter int MAX_BYTES  = 65536,
  parameter int STEP_BYTES = 16384,
  parameter int HEAD_BYTES = 32,
  parameter int DW         = 16,
  parameter int SW         = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  input  logic          cnt_last,
  input  logic [DW-1:0] pat,
  output logic          req_valid,
  output logic [1:0]    req_sel,
  output logic          req_write,
  output logic          req_byte,
  output logic [DW-1:0] req_wdata,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic [SW-1:0] cnt_limit,
  output logic          pat_load,
  output logic          pat_adv,
  output logic          done,
  output logic [SW-1:0] size_bytes
);
  localparam logic [SW-1:0] MAX_SZ     = SW'(MAX_BYTES);
  localparam logic [SW-1:0] STEP_SZ    = SW'(STEP_BYTES);
  localparam logic [SW-1:0] HEAD_WORDS = SW'(HEAD_BYTES / 2);

  st_t           state;
  logic [SW-1:0] cur_size;
  logic          byte_pass;
  logic          hs, is_ptr, rd_take, match;

  assign is_ptr    = (state == ST_PTR_H) || (state == ST_PTR_C) ||
                     (state == ST_PTR_F) || (state == ST_PTR_R);
  assign req_valid = is_ptr || (state == ST_CLR_H) || (state == ST_CLR_C) ||
                     (state == ST_FILL) || (state == ST_RD_REQ);
  assign hs        = req_valid && req_ready;
  assign req_sel   = (state == ST_PTR_R) ? SEL_RPTR : (is_ptr ? SEL_WPTR : SEL_DATA);
  assign req_write = (state != ST_RD_REQ);
  assign req_byte  = byte_pass && ((state == ST_FILL) || (state == ST_RD_REQ));

  always_comb begin
    req_wdata = '0;
    if (state == ST_FILL)
      req_wdata = byte_pass ? {{(DW-8){1'b0}}, pat[7:0]} : pat;
  end

  assign match   = byte_pass ? (rsp_data[7:0] == pat[7:0]) : (rsp_data == pat);
  assign rd_take = (state == ST_RD_WAIT) && rsp_valid;

  assign cnt_clr  = hs && is_ptr;
  assign cnt_inc  = (hs && ((state == ST_CLR_H) || (state == ST_CLR_C) || (state == ST_FILL)))
                    || rd_take;
  assign pat_load = hs && ((state == ST_PTR_F) || (state == ST_PTR_R));
  assign pat_adv  = (hs && (state == ST_FILL)) || rd_take;

  always_comb begin
    case (state)
      ST_CLR_H: cnt_limit = HEAD_WORDS;
      ST_CLR_C: cnt_limit = cur_size >> 1;
      default:  cnt_limit = byte_pass ? cur_size : (cur_size >> 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_size   <= '0;
      byte_pass  <= 1'b0;
      done       <= 1'b0;
      size_bytes <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          cur_size  <= MAX_SZ;
          byte_pass <= 1'b0;
          state     <= ST_PTR_H;
        end
        ST_PTR_H:  if (hs) state <= ST_CLR_H;
        ST_CLR_H:  if (hs && cnt_last) state <= ST_PTR_C;
        ST_PTR_C:  if (hs) state <= ST_CLR_C;
        ST_CLR_C:  if (hs && cnt_last) state <= ST_PTR_F;
        ST_PTR_F:  if (hs) state <= ST_FILL;
        ST_FILL:   if (hs && cnt_last) state <= ST_PTR_R;
        ST_PTR_R:  if (hs) state <= ST_RD_REQ;
        ST_RD_REQ: if (hs) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (rsp_valid) begin
          if (!match) begin
            if (cur_size <= STEP_SZ) begin
              done       <= 1'b1;
              size_bytes <= '0;
              state      <= ST_IDLE;
            end else begin
              cur_size  <= cur_size - STEP_SZ;
              byte_pass <= 1'b0;
              state     <= ST_PTR_H;
            end
          end else if (cnt_last) begin
            if (!byte_pass) begin
              byte_pass <= 1'b1;
              state     <= ST_PTR_H;
            end else begin
              done       <= 1'b1;
              size_bytes <= cur_size;
              state      <= ST_IDLE;
            end
          end else begin
            state <= ST_RD_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: an offered request stays put until accepted
  a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_sel) && $stable(req_write)
                                   && $stable(req_byte) && $stable(req_wdata)));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: a reported size is one of the candidates or zero
  a_r2_result_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((size_bytes <= MAX_SZ) && ((size_bytes % STEP_SZ) == '0)));

  // R10: a busy run only ends together with its completion pulse
  a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ((state != ST_IDLE) || done));

  // R6: a mismatch restarts the word pass on a smaller size or ends with zero
  a_r6_abandon: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !match) |=> ((state == ST_PTR_H && !byte_pass) || (done && size_bytes == '0)));
endmodule

// File: rtl/ramsz_probe.sv
module ramsz_probe
  import ramsz_pkg::*;
#(
  parameter  int MAX_BYTES  = 65536,
  parameter  int STEP_BYTES = 16384,
  parameter  int HEAD_BYTES = 32,
  localparam int DW         = 16,
  localparam int SIZE_W     = $clog2(MAX_BYTES) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_sel,
  output logic              req_write,
  output logic              req_byte,
  output logic [DW-1:0]     req_wdata,
  input  logic              rsp_valid,
  input  logic [DW-1:0]     rsp_data,
  output logic              done,
  output logic [SIZE_W-1:0] size_bytes
);
  logic              cnt_clr, cnt_inc, cnt_last, pat_load, pat_adv;
  logic [SIZE_W-1:0] cnt_limit;
  logic [DW-1:0]     pat;

  ramsz_seq #(
    .MAX_BYTES (MAX_BYTES),
    .STEP_BYTES(STEP_BYTES),
    .HEAD_BYTES(HEAD_BYTES),
    .DW        (DW),
    .SW        (SIZE_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .cnt_last  (cnt_last),
    .pat       (pat),
    .req_valid (req_valid),
    .req_sel   (req_sel),
    .req_write (req_write),
    .req_byte  (req_byte),
    .req_wdata (req_wdata),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc),
    .cnt_limit (cnt_limit),
    .pat_load  (pat_load),
    .pat_adv   (pat_adv),
    .done      (done),
    .size_bytes(size_bytes)
  );

  ramsz_loc_cnt #(.CW(SIZE_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .limit(cnt_limit),
    .last (cnt_last)
  );

  ramsz_patgen #(.DW(DW), .SEED(1), .INC(3)) u_pat (
    .clk  (clk),
    .rst_n(rst_n),
    .load (pat_load),
    .adv  (pat_adv),
    .pat  (pat)
  );
endmodule

// File: tb/sim_ramsz_probe.sv
module sim_ramsz_probe;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB  = 256;
  localparam int STEPB = 64;
  localparam int HEADB = 32;
  localparam int SW    = $clog2(MAXB) + 2;
  localparam int WDOG  = 150000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic req_valid, req_ready = 1'b0, req_write, req_byte, done;
  logic [1:0] req_sel;
  logic [15:0] req_wdata, rsp_data = 16'h0;
  logic rsp_valid = 1'b0;
  logic [SW-1:0] size_bytes;

  ramsz_probe #(.MAX_BYTES(MAXB), .STEP_BYTES(STEPB), .HEAD_BYTES(HEADB)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .req_write(req_write), .req_byte(req_byte), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .done(done), .size_bytes(size_bytes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [1:0]  sel;
    logic        wr;
    logic        by;
    logic [15:0] wd;
  } txn_t;

  int checks = 0, errors = 0;
  logic [7:0] mem [2][MAXB];
  int a_size = MAXB, fault = 0;
  int wp [2], rp [2];
  txn_t q [$];
  int exp_size = 0, got_done = 0, cyc = 0;
  bit timeout = 0, abort = 0, prev_done = 0;
  bit rsp_pend = 0, rsp_lat = 0;
  logic [15:0] rsp_val = 16'h0;
  logic [15:0] lf = 16'hACE1;

  function automatic logic [7:0] rd_b(int w, int a);
    logic [7:0] v = mem[w][a % a_size];
    if (fault == 2 && a >= 100) v[0] = 1'b1;
    return v;
  endfunction

  task automatic wr_b(int w, int a, logic [7:0] v, bit by);
    if (!(fault == 1 && by && (a % 2) == 1)) mem[w][a % a_size] = v;
  endtask

  task automatic port_op(int w, txn_t t, output logic [15:0] rd);
    rd = 16'h0;
    case (t.sel)
      2'd0: wp[w] = int'(t.wd);
      2'd1: rp[w] = int'(t.wd);
      default: begin
        if (t.wr) begin
          if (t.by) begin wr_b(w, wp[w], t.wd[7:0], 1'b1); wp[w] += 1; end
          else begin
            wr_b(w, wp[w], t.wd[7:0], 1'b0); wr_b(w, wp[w] + 1, t.wd[15:8], 1'b0); wp[w] += 2;
          end
        end else begin
          if (t.by) begin rd = {8'h0, rd_b(w, rp[w])}; rp[w] += 1; end
          else begin rd = {rd_b(w, rp[w] + 1), rd_b(w, rp[w])}; rp[w] += 2; end
        end
      end
    endcase
  endtask

  task automatic emit(logic [1:0] sel, bit wr, bit by, logic [15:0] wd, output logic [15:0] rd);
    txn_t t;
    t.sel = sel; t.wr = wr; t.by = by; t.wd = wd;
    q.push_back(t);
    port_op(0, t, rd);
  endtask

  task automatic ref_pass(int s, bit by, output bit ok);
    logic [15:0] rd, pat;
    int n = by ? s : s / 2;
    emit(2'd0, 1, 0, 16'h0, rd);
    for (int k = 0; k < HEADB / 2; k++) emit(2'd2, 1, 0, 16'h0, rd);
    emit(2'd0, 1, 0, 16'h0, rd);
    for (int k = 0; k < s / 2; k++) emit(2'd2, 1, 0, 16'h0, rd);
    emit(2'd0, 1, 0, 16'h0, rd);
    pat = 16'd1;
    for (int k = 0; k < n; k++) begin
      emit(2'd2, 1, by, by ? {8'h0, pat[7:0]} : pat, rd);
      pat += 16'd3;
    end
    emit(2'd1, 1, 0, 16'h0, rd);
    pat = 16'd1;
    ok = 1;
    for (int k = 0; k < n; k++) begin
      emit(2'd2, 0, by, 16'h0, rd);
      if (by ? (rd[7:0] != pat[7:0]) : (rd != pat)) begin ok = 0; break; end
      pat += 16'd3;
    end
  endtask

  task automatic gen_ref();
    bit ok;
    exp_size = 0;
    for (int s = MAXB; s > 0; s -= STEPB) begin
      ref_pass(s, 0, ok);
      if (ok) ref_pass(s, 1, ok);
      if (ok) begin exp_size = s; break; end
    end
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor on the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    if (cyc > WDOG && !timeout) begin
      timeout = 1;
      chk(0, "R2 watchdog expired, done", 0, 1);
    end
    if (rst_n) begin
      if ((rsp_pend || rsp_valid) && req_valid) chk(0, "R8 request while read outstanding", 1, 0);
      if (req_valid && req_ready && !abort) begin
        txn_t a, e;
        logic [15:0] rd;
        a.sel = req_sel; a.wr = req_write; a.by = req_byte; a.wd = req_wdata;
        if (q.size() == 0) begin
          chk(0, "R6 extra request", int'(a), -1);
          abort = 1;
        end else begin
          e = q.pop_front();
          if (e.sel != 2'd2) chk(a == e, "R3 pointer request", int'(a), int'(e));
          else if (!e.wr)    chk(a == e, "R6 read request", int'(a), int'(e));
          else if (e.by)     chk(a == e, "R5 byte write", int'(a), int'(e));
          else               chk(a == e, "R4 word write", int'(a), int'(e));
          if (a != e) abort = 1;
        end
        port_op(1, a, rd);
        if (!a.wr && a.sel == 2'd2) begin rsp_pend = 1; rsp_val = rd; rsp_lat = lf[2]; end
      end
      if (done) begin
        got_done++;
        chk(prev_done == 0, "R9 done longer than one cycle", 1, 0);
        chk(int'(size_bytes) == exp_size, "R2 reported size", int'(size_bytes), exp_size);
        chk(q.size() == 0, "R7 requests left unissued", q.size(), 0);
      end
      prev_done = done;
    end
  end

  // port driver just after the rising edge
  initial forever begin
    @(posedge clk);
    #1;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    req_ready = (lf[1:0] != 2'b00);
    if (rsp_valid) rsp_valid = 1'b0;
    else if (rsp_pend) begin
      if (rsp_lat) rsp_lat = 0;
      else begin rsp_valid = 1'b1; rsp_data = rsp_val; rsp_pend = 0; end
    end
  end

  task automatic run_scn(int asz, int f, bit mid_start);
    if (timeout) return;
    a_size = asz; fault = f; abort = 0;
    for (int i = 0; i < MAXB; i++) begin mem[0][i] = 8'hA5; mem[1][i] = 8'hA5; end
    wp[0] = 0; wp[1] = 0; rp[0] = 0; rp[1] = 0;
    q.delete();
    gen_ref();
    got_done = 0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (mid_start) begin
      repeat (60) @(posedge clk);
      #1 start = 1'b1;   // R10: ignored while busy
      @(posedge clk); #1 start = 1'b0;
    end
    wait (got_done > 0 || timeout);
    repeat (5) @(negedge clk);
    chk(int'(size_bytes) == exp_size, "R9 result held after done", int'(size_bytes), exp_size);
    chk(got_done == 1, "R10 number of completions", got_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R1 req_valid in reset", int'(req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid == 1'b0, "R1 req_valid after reset", int'(req_valid), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(size_bytes == '0, "R1 size after reset", int'(size_bytes), 0);
    run_scn(256, 0, 0);   // full RAM
    run_scn(128, 0, 1);   // aliased half RAM, start pulsed while busy
    run_scn(192, 0, 0);   // non-power-of-two RAM
    run_scn(256, 1, 0);   // odd byte writes lost: word pass ok, byte pass fails, result 0
    run_scn(256, 2, 0);   // stuck bit above address 100
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule